// File: doc/BRIEF.md
# Line Drive Soft-Start Controller

This block produces the drive pulse for a horizontal output stage from a line timebase that runs at a fixed number of clock ticks per line (432 by default, 6.75 MHz nominal). Each time the drive comes up from the off state, the pulse starts narrow and widens line by line until it reaches its steady width. The start width is about 2% of a line and the steady width is about 55%. The block removes the drive for three reasons: while the host holds standby, when the over-voltage protection trips, and when a power-on reset is seen. A protection trip or a power-on reset latches the drive off until the host sends an explicit restart command.

Next to the drive path sits a calibration handshake for the line oscillator. After power-on the block asks the oscillator to run above its nominal frequency. This request holds until the host has loaded the crystal information, has started calibration, and the oscillator reports that it has reached its nominal frequency. When the lock detector reports loss of coincidence, calibration runs again. The analog oscillator and the phase detector are outside the block and appear only as single-bit flags.

The reset input acts as a power-on reset. It leaves the drive latched off and the raised-frequency request asserted.

Top module: `line_drive_softstart`

## Requirements
- R1: The tick position counts 0 to LINE_TICKS-1 and wraps to 0. `line_start` is high exactly in the cycle where the position is 0.
- R2: A drive pulse always begins at position 0 and stays high for H ticks. On the k-th running line (k = 0 for the first line after the drive comes up), H = START_HIGH + floor((FINAL_HIGH-START_HIGH)*min(k,RAMP_LINES)/RAMP_LINES). The defaults are 9, 238 and 300.
- R3: From line RAMP_LINES onward the pulse width stays at FINAL_HIGH on every line.
- R4: While `standby` is high, `hdrive` is low from the next cycle on. After `standby` falls, the drive returns at a line start and restarts the ramp at START_HIGH.
- R5: An `ovp_trip` or `por_pulse` forces `hdrive` low from the next cycle. The drive stays off after the fault input clears, and comes back only after a `restart_cmd` pulse. It then ramps from START_HIGH.
- R6: If `restart_cmd` arrives in the same cycle as `ovp_trip` or `por_pulse`, the fault wins and the drive stays off.
- R7: After reset or `por_pulse`, `osc_high` is 1 and `cal_active` is 0, and any crystal information already loaded is discarded.
- R8: `cal_start` is ignored unless `xtal_loaded` has pulsed since the last power-on reset. When it is accepted, `cal_active` is 1 in the next cycle.
- R9: `freq_reached` while `cal_active` is 1 clears both `cal_active` and `osc_high` in the next cycle.
- R10: Once crystal information is loaded, `coinc_lost` sets `cal_active`. If `coinc_lost` and `freq_reached` arrive in the same cycle, calibration stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line timebase clock (LINE_TICKS per line) |
| rst_n | input | 1 | Active-low power-on reset |
| standby | input | 1 | Host standby level; drive off while high |
| ovp_trip | input | 1 | Over-voltage protection trip |
| por_pulse | input | 1 | Detected power-on reset event |
| restart_cmd | input | 1 | Host command pulse that re-enables a latched-off drive |
| xtal_loaded | input | 1 | Pulse: crystal information loaded by host |
| cal_start | input | 1 | Pulse: host requests line oscillator calibration |
| freq_reached | input | 1 | Oscillator reports nominal frequency |
| coinc_lost | input | 1 | Coincidence detector reports loss of lock |
| hdrive | output | 1 | Horizontal output-stage drive pulse |
| drive_run | output | 1 | Drive is running (pulses are being produced) |
| line_start | output | 1 | High in the cycle at tick position 0 |
| osc_high | output | 1 | Request to hold the oscillator above nominal |
| cal_active | output | 1 | Calibration in progress |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a host restart and a protection fault. The bench holds `ovp_trip` high while it pulses `restart_cmd`, and it passes only if a whole line after that stays free of pulses. The second pair is the end of calibration and a new loss of lock. The bench raises `freq_reached` and `coinc_lost` together and expects `cal_active` to stay set, then expects a lone `freq_reached` to clear both `cal_active` and `osc_high`. Each pulse width in the ramp, including the steady widths after the ramp ends, goes through a queue, and the bench compares it against its own line-by-line accumulation of the width formula.

// File: rtl/lds_pkg.sv
package lds_pkg;

  // High time (ticks) of the k-th running line of the soft-start ramp.
  function automatic int unsigned ramp_high(input int unsigned k,
                                            input int unsigned start_hi,
                                            input int unsigned final_hi,
                                            input int unsigned ramp_lines);
    int unsigned kk;
    kk = (k >= ramp_lines) ? ramp_lines : k;
    return start_hi + ((final_hi - start_hi) * kk) / ramp_lines;
  endfunction

endpackage

// File: rtl/lds_line_timer.sv
module lds_line_timer #(
  parameter int LINE_TICKS = 432,
  localparam int PW = $clog2(LINE_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] pos,
  output logic          line_end,
  output logic          line_start
);
  localparam logic [PW-1:0] LAST = PW'(LINE_TICKS - 1);

  assign line_end   = (pos == LAST);
  assign line_start = (pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (line_end) pos <= '0;
    else               pos <= pos + 1'b1;
  end
endmodule

// File: rtl/lds_drive_gate.sv
module lds_drive_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic ovp_trip,
  input  logic por_pulse,
  input  logic restart_cmd,
  input  logic line_end,
  output logic run,
  output logic latched
);
  logic fault;
  logic allow;

  assign fault = ovp_trip | por_pulse;
  // Fault inputs gate directly so the drive drops one cycle after a trip.
  assign allow = !latched && !standby && !fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b1;
      run     <= 1'b0;
    end else begin
      if (fault)            latched <= 1'b1;
      else if (restart_cmd) latched <= 1'b0;

      if (!allow)        run <= 1'b0;
      else if (line_end) run <= 1'b1;
    end
  end
endmodule

// File: rtl/lds_duty_ramp.sv
module lds_duty_ramp #(
  parameter int LINE_TICKS = 432,
  parameter int START_HIGH = 9,
  parameter int FINAL_HIGH = 238,
  parameter int RAMP_LINES = 300,
  localparam int PW = $clog2(LINE_TICKS),
  localparam int RW = $clog2(RAMP_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line_end,
  input  logic [PW-1:0] pos,
  output logic [PW-1:0] high_ticks,
  output logic          hdrive
);
  localparam logic [RW-1:0] RAMP_END = RW'(RAMP_LINES);

  logic [RW-1:0] line_idx;

  assign high_ticks = PW'(lds_pkg::ramp_high(32'(line_idx), START_HIGH,
                                             FINAL_HIGH, RAMP_LINES));
  assign hdrive = run && (pos < high_ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               line_idx <= '0;
    else if (!run)                            line_idx <= '0;
    else if (line_end && line_idx < RAMP_END) line_idx <= line_idx + 1'b1;
  end
endmodule

// File: rtl/lds_cal_ctrl.sv
module lds_cal_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic por_pulse,
  input  logic xtal_loaded,
  input  logic cal_start,
  input  logic freq_reached,
  input  logic coinc_lost,
  output logic osc_high,
  output logic cal_active
);
  logic xtal_ok;
  logic cal_req;
  logic cal_done;

  assign cal_req  = xtal_ok && (cal_start || coinc_lost);
  assign cal_done = cal_active && freq_reached && !coinc_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_ok    <= 1'b0;
      osc_high   <= 1'b1;
      cal_active <= 1'b0;
    end else if (por_pulse) begin
      xtal_ok    <= 1'b0;
      osc_high   <= 1'b1;
      cal_active <= 1'b0;
    end else begin
      if (xtal_loaded) xtal_ok <= 1'b1;
      if (cal_req)       cal_active <= 1'b1;
      else if (cal_done) cal_active <= 1'b0;
      if (cal_done) osc_high <= 1'b0;
    end
  end
endmodule

// File: rtl/line_drive_softstart.sv
module line_drive_softstart #(
  parameter int LINE_TICKS = 432,
  parameter int START_HIGH = 9,
  parameter int FINAL_HIGH = 238,
  parameter int RAMP_LINES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic ovp_trip,
  input  logic por_pulse,
  input  logic restart_cmd,
  input  logic xtal_loaded,
  input  logic cal_start,
  input  logic freq_reached,
  input  logic coinc_lost,
  output logic hdrive,
  output logic drive_run,
  output logic line_start,
  output logic osc_high,
  output logic cal_active
);
  localparam int PW = $clog2(LINE_TICKS);

  logic [PW-1:0] pos;
  logic [PW-1:0] high_ticks;
  logic          line_end;
  logic          latched;

  lds_line_timer #(.LINE_TICKS(LINE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .pos(pos),
    .line_end(line_end), .line_start(line_start)
  );

  lds_drive_gate u_gate (
    .clk(clk), .rst_n(rst_n), .standby(standby), .ovp_trip(ovp_trip),
    .por_pulse(por_pulse), .restart_cmd(restart_cmd),
    .line_end(line_end), .run(drive_run), .latched(latched)
  );

  lds_duty_ramp #(
    .LINE_TICKS(LINE_TICKS), .START_HIGH(START_HIGH),
    .FINAL_HIGH(FINAL_HIGH), .RAMP_LINES(RAMP_LINES)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(drive_run), .line_end(line_end),
    .pos(pos), .high_ticks(high_ticks), .hdrive(hdrive)
  );

  lds_cal_ctrl u_cal (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse),
    .xtal_loaded(xtal_loaded), .cal_start(cal_start),
    .freq_reached(freq_reached), .coinc_lost(coinc_lost),
    .osc_high(osc_high), .cal_active(cal_active)
  );
endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
  parameter int LINE_TICKS = 432,
  parameter int FINAL_HIGH = 238,
  localparam int PW = $clog2(LINE_TICKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby,
  input logic          ovp_trip,
  input logic          por_pulse,
  input logic          restart_cmd,
  input logic          freq_reached,
  input logic          coinc_lost,
  input logic          hdrive,
  input logic          cal_active,
  input logic          osc_high,
  input logic          latched,
  input logic [PW-1:0] pos,
  input logic [PW-1:0] high_ticks
);
  localparam logic [PW-1:0] LAST = PW'(LINE_TICKS - 1);

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    pos == LAST |=> pos == '0);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    pos != LAST |=> pos == PW'($past(pos) + 1'b1));
  a_r2_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrive) |-> pos == '0);
  a_r3_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    high_ticks <= PW'(FINAL_HIGH));
  a_r4_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !hdrive);
  a_r5_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_trip || por_pulse) |=> (!hdrive && latched));
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !restart_cmd) |=> latched);
  a_r7_por_cal: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> (osc_high && !cal_active));
  a_r9_cal_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && freq_reached && !coinc_lost && !por_pulse)
      |=> (!cal_active && !osc_high));
  a_r10_lost_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && coinc_lost && !por_pulse) |=> cal_active);
endmodule

bind line_drive_softstart lds_checker #(
  .LINE_TICKS(LINE_TICKS), .FINAL_HIGH(FINAL_HIGH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .ovp_trip(ovp_trip),
  .por_pulse(por_pulse), .restart_cmd(restart_cmd),
  .freq_reached(freq_reached), .coinc_lost(coinc_lost),
  .hdrive(hdrive), .cal_active(cal_active), .osc_high(osc_high),
  .latched(latched), .pos(pos), .high_ticks(high_ticks)
);

// File: tb/line_drive_softstart_tb.sv
module line_drive_softstart_tb;
  localparam int LT = 432;
  localparam int SH = 9;
  localparam int FH = 238;
  localparam int RL = 40;

  logic clk = 0, rst_n = 0;
  logic standby = 0, ovp_trip = 0, por_pulse = 0, restart_cmd = 0;
  logic xtal_loaded = 0, cal_start = 0, freq_reached = 0, coinc_lost = 0;
  logic hdrive, drive_run, line_start, osc_high, cal_active;

  int checks = 0, failures = 0, cycles = 0;
  int exp_q[$];
  int hi_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  line_drive_softstart #(.LINE_TICKS(LT), .START_HIGH(SH),
                         .FINAL_HIGH(FH), .RAMP_LINES(RL)) u_dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .ovp_trip(ovp_trip),
    .por_pulse(por_pulse), .restart_cmd(restart_cmd),
    .xtal_loaded(xtal_loaded), .cal_start(cal_start),
    .freq_reached(freq_reached), .coinc_lost(coinc_lost),
    .hdrive(hdrive), .drive_run(drive_run), .line_start(line_start),
    .osc_high(osc_high), .cal_active(cal_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: push the expected widths of n ramp lines, accumulating width steps.
  task automatic push_ramp(input int n);
    int acc = 0;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(SH + acc / RL);
      if (k < RL) acc += (FH - SH);
    end
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 200 * LT) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic check_quiet(input string req);
    int hi = 0;
    repeat (LT) begin
      @(negedge clk);
      hi += int'(hdrive);
    end
    check(hi == 0, req, hi, 0);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1;
    @(negedge clk) sig = 0;
  endtask

  // Monitor: measure each drive pulse and compare with the queue head.
  always @(negedge clk) begin
    if (rst_n) begin
      if (hdrive) hi_cnt++;
      else if (hi_cnt > 0) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected pulse", hi_cnt, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(hi_cnt == e, (e == FH) ? "R3 steady width" : "R2 ramp width", hi_cnt, e);
        end
        hi_cnt = 0;
      end
    end
  end

  // line_start position check (R1): exactly once every LT cycles
  int ls_gap = -1;
  always @(negedge clk) begin
    if (rst_n && line_start) begin
      if (ls_gap >= 0 && ls_gap != LT) check(0, "R1 line period", ls_gap, LT);
      ls_gap = 0;
    end
    if (ls_gap >= 0) ls_gap++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(hdrive == 0, "R7 reset hdrive", hdrive, 0);
    check(osc_high == 1, "R7 reset osc_high", osc_high, 1);
    check(cal_active == 0, "R7 reset cal_active", cal_active, 0);
    @(negedge clk) rst_n = 1;
    // R1 line_start period
    gap = 0;
    while (!line_start) begin @(negedge clk); gap++; end
    repeat (LT) @(negedge clk);
    check(line_start == 1, "R1 line_start after one line", line_start, 1);
    // R5 latched off after power-on reset
    check_quiet("R5 off after reset");
    // R8 cal_start before crystal load is ignored
    pulse(cal_start);
    check(cal_active == 0, "R8 early cal_start ignored", cal_active, 0);
    pulse(xtal_loaded);
    pulse(cal_start);
    check(cal_active == 1, "R8 cal accepted", cal_active, 1);
    check(osc_high == 1, "R8 osc_high held in cal", osc_high, 1);
    pulse(freq_reached);
    check(cal_active == 0, "R9 cal done", cal_active, 0);
    check(osc_high == 0, "R9 osc_high cleared", osc_high, 0);
    // R2/R3 full ramp and steady width
    pulse(restart_cmd);
    push_ramp(RL + 5);
    drain("R2 ramp drained");
    check(drive_run == 1, "R2 running", drive_run, 1);
    // R4 standby
    @(negedge clk) standby = 1;
    check_quiet("R4 standby quiet");
    check_quiet("R4 standby quiet 2");
    @(negedge clk) standby = 0;
    push_ramp(3);
    drain("R4 ramp restarts");
    // R5/R6 over-voltage latch
    @(negedge clk) ovp_trip = 1;
    check_quiet("R5 ovp quiet");
    @(negedge clk) restart_cmd = 1;
    @(negedge clk) restart_cmd = 0;
    check_quiet("R6 restart with fault ignored");
    @(negedge clk) ovp_trip = 0;
    check_quiet("R5 stays off after fault clears");
    check(drive_run == 0, "R5 not running", drive_run, 0);
    pulse(restart_cmd);
    push_ramp(3);
    drain("R5 ramp after restart");
    // R5/R7 power-on reset event
    pulse(por_pulse);
    check(osc_high == 1, "R7 por osc_high", osc_high, 1);
    check(cal_active == 0, "R7 por cal_active", cal_active, 0);
    check_quiet("R5 por quiet");
    pulse(cal_start);
    check(cal_active == 0, "R7 crystal info discarded", cal_active, 0);
    pulse(coinc_lost);
    check(cal_active == 0, "R10 lost ignored without crystal", cal_active, 0);
    pulse(xtal_loaded);
    pulse(cal_start);
    check(cal_active == 1, "R8 cal after reload", cal_active, 1);
    // R10 simultaneous coinc_lost and freq_reached
    @(negedge clk) begin freq_reached = 1; coinc_lost = 1; end
    @(negedge clk) begin freq_reached = 0; coinc_lost = 0; end
    check(cal_active == 1, "R10 lost wins over done", cal_active, 1);
    check(osc_high == 1, "R10 osc_high kept", osc_high, 1);
    pulse(freq_reached);
    check(cal_active == 0, "R9 done after collision", cal_active, 0);
    check(osc_high == 0, "R9 osc_high clear", osc_high, 0);
    pulse(coinc_lost);
    check(cal_active == 1, "R10 recal on lock loss", cal_active, 1);
    check(osc_high == 0, "R10 osc_high unchanged", osc_high, 0);
    pulse(freq_reached);
    check(cal_active == 0, "R9 recal done", cal_active, 0);
    check(hdrive == 0, "R5 still off after por", hdrive, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule